// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel characters into a non-return-to-zero serial stream. A character written on the parallel port lands in a holding register. From there it moves into a hidden shift register, which sends a frame. The frame is a start bit at the space level, then 8 or 9 data bits with the least significant bit first, then one or two stop bits at the mark level. Between frames the line rests at the mark level.

Because there are two registers, one character can wait while another is on the wire. The waiting character moves into the shift register in the clock cycle that follows the end of the last stop bit. A registered flag shows software when the holding register can take another character. An output polarity select can invert the entire line. An external baud tick, one cycle wide, sets the bit period. The 9-bit mode, the ninth bit and the stop count are all captured together with each written character.

Top module: `serial_tx_buffered`

## Requirements
- R1: With both enables high and no frame in progress, the line rests at the mark level. Mark is 1 when `invert_line`=0.
- R2: A frame has these parts, in order: one start bit at space level (0 when not inverted), then data bits from bit 0 upward, then stop bits at mark level.
- R3: When `nine_bit_mode`=1 at the write, a ninth data bit is sent after data bit 7. Its value is `ninth_bit` as sampled at the write. The block computes no parity.
- R4: A write taken at clock edge N while both registers are empty reaches the line as a start bit after edge N+1. The line stays at mark after edge N.
- R5: A character waiting in the holding register is moved on the edge after the edge that ends the last stop bit. The line therefore shows exactly one cycle of mark between the two frames.
- R6: `invert_line`=1 inverts the line in every state. The idle level becomes 0 and the data bits are complemented.
- R7: `hold_empty_flag` is 1 whenever both enables are high and the holding register is empty. It is 0 only while a frame is being sent and another character waits. It is also 0 when either enable is low.
- R8: After a write at edge N, `hold_empty_flag` keeps its old value after edge N. It shows the new state after edge N+1.
- R9: While either enable is low, both registers are emptied and the line drives the idle level. Characters cleared in this way are never sent later.
- R10: A write while the holding register is full is dropped. The held character is kept, and `overwrite_err` becomes 1 and stays at 1 until reset.
- R11: `two_stop`, sampled at the write, selects two stop bits (1) or one stop bit (0).
- R12: During a frame, the line changes only on a clock edge at which `baud_tick` is high. The one exception is the start of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmitter enable |
| port_enable | input | 1 | Serial port enable |
| nine_bit_mode | input | 1 | Send 9 data bits for the written character |
| ninth_bit | input | 1 | Ninth data bit captured with the write |
| two_stop | input | 1 | Two stop bits for the written character |
| invert_line | input | 1 | Invert the serial output |
| baud_tick | input | 1 | One-cycle pulse that ends each bit period |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| line_out | output | 1 | Serial line, registered |
| hold_empty_flag | output | 1 | Holding register empty, registered |
| overwrite_err | output | 1 | Sticky flag for a dropped write |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse and that `invert_line` is changed only while the line is idle. They also assume that a write never coincides with the cycle in which a waiting character is moved to the shift register. The stimulus meets these conditions in the following ways. A free-running divider produces the ticks, and the divider is paused only as a whole. Polarity changes only after the frame queue has drained. The second and third writes of a burst are placed a few cycles after the first frame has started, well before any stop bit.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;

  // Per-character frame settings captured at the holding-register write
  typedef struct packed {
    logic nine_en;
    logic two_stop;
  } frame_attr_t;

endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_extra,
  input  frame_attr_t       wr_attr,
  input  logic              take,
  output logic              full,
  output logic [DATA_W:0]   data,
  output frame_attr_t       attr,
  output logic              err
);

  logic            full_q;
  logic [DATA_W:0] data_q;
  frame_attr_t     attr_q;
  logic            err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
      attr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (!en) begin
        full_q <= 1'b0;
      end else if (take) begin
        full_q <= 1'b0;
      end else if (wr_valid && !full_q) begin
        full_q <= 1'b1;
        data_q <= {wr_extra & wr_attr.nine_en, wr_data};
        attr_q <= wr_attr;
      end
      if (en && wr_valid && full_q) begin
        err_q <= 1'b1;
      end
    end
  end

  assign full = full_q;
  assign data = data_q;
  assign attr = attr_q;
  assign err  = err_q;

  assert_full_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (en && wr_valid && full_q) |=> (err_q && (data_q == $past(data_q))));

  assert_disable_empties_R9: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> (!full_q));

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            load,
  input  logic [DATA_W:0] ld_data,
  input  frame_attr_t     ld_attr,
  input  logic            tick,
  input  logic            invert,
  output logic            busy,
  output logic            line
);

  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_8 = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_9 = CNT_W'(DATA_W);

  tx_state_e        state_q, state_d;
  logic [DATA_W:0]  shreg_q, shreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  frame_attr_t      attr_q, attr_d;
  logic             lvl_q, lvl_d;
  logic             line_q;
  logic [CNT_W-1:0] last_data;
  logic [CNT_W-1:0] last_stop;

  assign last_data = attr_q.nine_en ? LAST_9 : LAST_8;
  assign last_stop = attr_q.two_stop ? CNT_W'(1) : '0;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    attr_d  = attr_q;
    lvl_d   = lvl_q;
    if (!en) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      lvl_d   = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          lvl_d = 1'b1;
          if (load) begin
            state_d = ST_START;
            shreg_d = ld_data;
            attr_d  = ld_attr;
            cnt_d   = '0;
            lvl_d   = 1'b0;
          end
        end
        ST_START: begin
          if (tick) begin
            state_d = ST_DATA;
            lvl_d   = shreg_q[0];
            shreg_d = {1'b0, shreg_q[DATA_W:1]};
            cnt_d   = '0;
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (cnt_q == last_data) begin
              state_d = ST_STOP;
              lvl_d   = 1'b1;
              cnt_d   = '0;
            end else begin
              lvl_d   = shreg_q[0];
              shreg_d = {1'b0, shreg_q[DATA_W:1]};
              cnt_d   = cnt_q + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (cnt_q == last_stop) begin
              state_d = ST_IDLE;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      attr_q  <= '0;
      lvl_q   <= 1'b1;
      line_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      attr_q  <= attr_d;
      lvl_q   <= lvl_d;
      line_q  <= lvl_d ^ invert;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign line = line_q;

  assert_start_is_space_R2: assert property (@(posedge clk) disable iff (rst)
    (en && load && state_q == ST_IDLE) |=> (lvl_q == 1'b0));

  assert_hold_without_tick_R12: assert property (@(posedge clk) disable iff (rst)
    (en && state_q != ST_IDLE && !tick) |=> (lvl_q == $past(lvl_q)));

  assert_disabled_line_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> (line_q == !$past(invert)));

endmodule

// File: rtl/tx_flag_gen.sv
module tx_flag_gen (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic busy,
  input  logic full,
  output logic flag
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= en & ~(busy & full);
    end
  end

  assign flag = flag_q;

  assert_flag_set_when_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (en && !full) |=> flag_q);

  assert_flag_clear_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> (!flag_q));

endmodule

// File: rtl/serial_tx_buffered.sv
module serial_tx_buffered
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_enable,
  input  logic              port_enable,
  input  logic              nine_bit_mode,
  input  logic              ninth_bit,
  input  logic              two_stop,
  input  logic              invert_line,
  input  logic              baud_tick,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              line_out,
  output logic              hold_empty_flag,
  output logic              overwrite_err
);

  logic            en;
  logic            hold_full;
  logic [DATA_W:0] hold_data;
  frame_attr_t     hold_attr;
  frame_attr_t     wr_attr;
  logic            busy;
  logic            xfer;

  assign en               = tx_enable & port_enable;
  assign wr_attr.nine_en  = nine_bit_mode;
  assign wr_attr.two_stop = two_stop;
  assign xfer             = en & hold_full & ~busy;

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .wr_extra (ninth_bit),
    .wr_attr  (wr_attr),
    .take     (xfer),
    .full     (hold_full),
    .data     (hold_data),
    .attr     (hold_attr),
    .err      (overwrite_err)
  );

  tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .load    (xfer),
    .ld_data (hold_data),
    .ld_attr (hold_attr),
    .tick    (baud_tick),
    .invert  (invert_line),
    .busy    (busy),
    .line    (line_out)
  );

  tx_flag_gen u_flag (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .busy (busy),
    .full (hold_full),
    .flag (hold_empty_flag)
  );

  assert_handoff_next_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    (en && hold_full && !busy) |=> busy);

  assert_flag_lag_R8: assert property (@(posedge clk) disable iff (rst)
    (en && wr_valid && !hold_full && busy) |=> hold_empty_flag);

endmodule

// File: tb/serial_tx_buffered_tb.sv
module serial_tx_buffered_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BAUD       = 8;

  typedef struct {
    logic [8:0] data;
    logic       nine;
    logic       two;
  } frame_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_enable = 1'b0;
  logic       port_enable = 1'b0;
  logic       nine_bit_mode = 1'b0;
  logic       ninth_bit = 1'b0;
  logic       two_stop = 1'b0;
  logic       invert_line = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       line_out;
  logic       hold_empty_flag;
  logic       overwrite_err;

  int tests = 0;
  int fails = 0;
  bit tick_on = 1'b0;
  bit mon_abort = 1'b0;
  int tcnt = 0;

  frame_t exp_q[$];
  frame_t cur;
  int     phase = 0;
  int     idx = 0;
  int     sidx = 0;
  bit     gap_pend = 1'b0;
  logic   lvl;
  logic   exp_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_tx_buffered u_dut (
    .clk             (clk),
    .rst             (rst),
    .tx_enable       (tx_enable),
    .port_enable     (port_enable),
    .nine_bit_mode   (nine_bit_mode),
    .ninth_bit       (ninth_bit),
    .two_stop        (two_stop),
    .invert_line     (invert_line),
    .baud_tick       (baud_tick),
    .wr_valid        (wr_valid),
    .wr_data         (wr_data),
    .line_out        (line_out),
    .hold_empty_flag (hold_empty_flag),
    .overwrite_err   (overwrite_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // baud tick divider
  always @(negedge clk) begin
    if (!tick_on) begin
      tcnt      <= 0;
      baud_tick <= 1'b0;
    end else begin
      tcnt      <= (tcnt == BAUD-1) ? 0 : tcnt + 1;
      baud_tick <= (tcnt == BAUD-1);
    end
  end

  // monitor: decodes frames from the line and compares with the scoreboard
  always @(negedge clk) begin
    if (rst || mon_abort) begin
      phase    = 0;
      gap_pend = 1'b0;
    end else begin
      lvl = line_out ^ invert_line;
      if (gap_pend) begin
        chk(lvl == 1'b0, "R5 start one cycle after stop", int'(lvl), 0);
        gap_pend = 1'b0;
      end
      case (phase)
        0: if (lvl == 1'b0) begin
             if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected frame", 1, 0);
             end else begin
               cur   = exp_q.pop_front();
               phase = 1;
               idx   = 0;
             end
           end
        1: if (baud_tick) begin
             exp_b = (idx == 8) ? cur.data[8] : cur.data[idx];
             if (idx == 8)
               chk(lvl == exp_b, "R3 ninth bit", int'(lvl), int'(exp_b));
             else if (invert_line)
               chk(lvl == exp_b, "R6 inverted data bit", int'(lvl), int'(exp_b));
             else
               chk(lvl == exp_b, "R2 data bit", int'(lvl), int'(exp_b));
             idx++;
             if (idx == (cur.nine ? 9 : 8)) begin
               phase = 2;
               sidx  = 0;
             end
           end
        default: if (baud_tick) begin
             chk(lvl == 1'b1, "R11 stop bit mark", int'(lvl), 1);
             sidx++;
             if (sidx == (cur.two ? 3 : 2)) begin
               phase    = 0;
               gap_pend = (exp_q.size() > 0);
             end
           end
      endcase
    end
  end

  task automatic push(input logic [7:0] d);
    frame_t f;
    f.data = {nine_bit_mode & ninth_bit, d};
    f.nine = nine_bit_mode;
    f.two  = two_stop;
    exp_q.push_back(f);
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    wr_valid <= 1'b1;
    wr_data  <= d;
    push(d);
    @(negedge clk);
    wr_valid <= 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && phase == 0 && !gap_pend) break;
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && phase == 0, "R2 all frames sent", exp_q.size(), 0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none

    repeat (4) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(line_out == 1'b1, "R1 reset line mark", int'(line_out), 1);
    chk(hold_empty_flag == 1'b0, "R7 flag low while disabled", int'(hold_empty_flag), 0);
    chk(overwrite_err == 1'b0, "R10 err clear at reset", int'(overwrite_err), 0);

    tx_enable   <= 1'b1;
    port_enable <= 1'b1;
    tick_on     <= 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(hold_empty_flag == 1'b1, "R7 flag set on enable", int'(hold_empty_flag), 1);
    chk(line_out == 1'b1, "R1 idle mark when enabled", int'(line_out), 1);

    // R4, R8, R10 directed timing
    @(negedge clk);
    wr_valid <= 1'b1;
    wr_data  <= 8'hA5;
    push(8'hA5);
    @(negedge clk);
    wr_valid <= 1'b0;
    chk(line_out == 1'b1, "R4 line still mark after write edge", int'(line_out), 1);
    chk(hold_empty_flag == 1'b1, "R7 flag stays set with shift idle", int'(hold_empty_flag), 1);
    @(negedge clk);
    chk(line_out == 1'b0, "R4 start bit after next edge", int'(line_out), 0);
    wr_valid <= 1'b1;
    wr_data  <= 8'h5A;
    push(8'h5A);
    @(negedge clk);
    wr_valid <= 1'b0;
    chk(hold_empty_flag == 1'b1, "R8 flag unchanged after write edge", int'(hold_empty_flag), 1);
    @(negedge clk);
    chk(hold_empty_flag == 1'b0, "R8 flag clear one edge later", int'(hold_empty_flag), 0);
    wr_valid <= 1'b1;
    wr_data  <= 8'hFF;
    @(negedge clk);
    wr_valid <= 1'b0;
    @(negedge clk);
    chk(overwrite_err == 1'b1, "R10 overwrite error set", int'(overwrite_err), 1);
    drain();
    chk(hold_empty_flag == 1'b1, "R7 flag set when drained", int'(hold_empty_flag), 1);
    chk(overwrite_err == 1'b1, "R10 overwrite error sticky", int'(overwrite_err), 1);

    // R3, R11: nine bits, two stops, back to back
    nine_bit_mode <= 1'b1;
    ninth_bit     <= 1'b1;
    two_stop      <= 1'b1;
    @(negedge clk);
    send(8'h3C);
    ninth_bit <= 1'b0;
    repeat (3) @(negedge clk);
    send(8'hC3);
    drain();
    nine_bit_mode <= 1'b0;
    two_stop      <= 1'b0;

    // R6: inverted line
    invert_line <= 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(line_out == 1'b0, "R6 inverted idle low", int'(line_out), 0);
    send(8'h81);
    repeat (3) @(negedge clk);
    send(8'h7E);
    drain();
    invert_line <= 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(line_out == 1'b1, "R6 normal idle high again", int'(line_out), 1);

    // R9: disable mid-frame drops both characters
    send(8'h55);
    repeat (3) @(negedge clk);
    send(8'hAA);
    repeat (20) @(negedge clk);
    tx_enable <= 1'b0;
    mon_abort <= 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(line_out == 1'b1, "R9 line idle when disabled", int'(line_out), 1);
    chk(hold_empty_flag == 1'b0, "R7 flag low when disabled", int'(hold_empty_flag), 0);
    exp_q.delete();
    tx_enable <= 1'b1;
    mon_abort <= 1'b0;
    begin
      bit stayed = 1'b1;
      for (int i = 0; i < 120; i++) begin
        @(negedge clk);
        if (line_out != 1'b1) stayed = 1'b0;
      end
      chk(stayed, "R9 no stale frame after re-enable", int'(stayed), 1);
    end
    chk(hold_empty_flag == 1'b1, "R7 flag set after re-enable", int'(hold_empty_flag), 1);

    port_enable <= 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(hold_empty_flag == 1'b0, "R7 port enable gates flag", int'(hold_empty_flag), 0);
    port_enable <= 1'b1;
    @(negedge clk);

    // R12: no ticks, no bit change
    send(8'h0F);
    repeat (2) @(negedge clk);
    tick_on <= 1'b0;
    @(negedge clk);
    @(negedge clk);
    begin
      logic held = line_out;
      bit steady = 1'b1;
      for (int i = 0; i < 25; i++) begin
        @(negedge clk);
        if (line_out != held) steady = 1'b0;
      end
      chk(steady, "R12 line frozen without ticks", int'(steady), 1);
    end
    tick_on <= 1'b1;
    drain();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule